// File: doc/BRIEF.md
# Fault-Bypass Mesh Router Datapath

This block is the flit datapath of a five-port wormhole router for a two-dimensional mesh on-chip network. It has four neighbour ports (east, west, north, south) and one port to the local core. Every input port buffers flits in two virtual-channel FIFOs. A crossbar carries each packet from its input to the output named in its head flit. A per-output round-robin arbiter keeps that output with one input from the head flit until the tail flit has passed.

Beside the crossbar sits a crossbar-free backup lane that follows a fixed one-way ring direction: it runs from the west input to the east output. The east output has a three-way selector. It takes the crossbar result when the router is healthy. When a fault flag is set, it takes either the backup lane from the west input or the local core's injection. Packets on the backup lane whose head flit addresses the local core are ejected straight to the core output instead. Two static flags mark a failed crossbar and a failed core interface. With either flag set, the core can still inject through the east output and receive from the west input. Ports that stay healthy keep using the crossbar.

Top module: `fbr_router`

## Requirements
- R1: During and just after reset every `out_valid` bit is low and every `in_ready` bit is high.
- R2: Flit bit 63 marks a head flit and bit 62 marks a tail flit. Kind 10 is head, 00 is body, 01 is tail and 11 is a single-flit packet. A head flit carries its destination in bits 2:0: 0 east, 1 west, 2 north, 3 south, 4 local. With both fault flags low, every flit of a packet leaves on the destination output, on the virtual channel it arrived on, in order.
- R3: A flit moves only when valid is high and the ready bit of its virtual channel is high. `in_ready[p][v]` is low only while that FIFO holds DEPTH flits. A flit taken at a clock edge is visible at an idle output right after that edge.
- R4: Once an output has started a packet, it carries only that packet's flits until the tail flit has passed.
- R5: When several inputs compete for one output, grants rotate round-robin at packet boundaries, so two busy inputs alternate packet by packet.
- R6: An input with no packet in progress serves its lowest-numbered non-empty virtual channel and keeps that channel until the tail flit leaves.
- R7: With `fault_xbar` high, the west, north and south outputs stay idle. Flits already queued at other inputs stay queued and are delivered once the flag drops.
- R8: With either fault flag high, the east output is fed only by the backup lane (west input) and the local input. The two alternate round-robin at packet boundaries.
- R9: With either fault flag high, a west-input packet whose destination is 4 leaves on the local output. Any other destination leaves on the east output.
- R10: With only `fault_ni` high, local injection goes out east through the selector, and the east, north and south inputs still reach the west, north and south outputs through the crossbar.
- R11: While an output is valid and its virtual channel is not ready, it stays valid with the same flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_xbar | input | 1 | Static flag: crossbar failed |
| fault_ni | input | 1 | Static flag: core interface failed |
| in_valid | input | 5 | Flit valid per input port |
| in_vc | input | 5x1 | Virtual channel of the offered flit |
| in_flit | input | 5x64 | Offered flit per input port |
| in_ready | output | 5x2 | Space available, per port and virtual channel |
| out_valid | output | 5 | Flit valid per output port |
| out_vc | output | 5x1 | Virtual channel of the outgoing flit |
| out_flit | output | 5x64 | Outgoing flit per output port |
| out_ready | input | 5x2 | Downstream ready, per port and virtual channel |

## Verification
The only register between an input and an output is the input FIFO. A flit taken at one rising edge is therefore due at the output in the same cycle, after that edge. Ready and the input-FIFO fill level change at the edge where the flit is taken. The bench drives and samples only on falling edges. It checks a single flit exactly one edge after offering it, and it records every output transfer on the falling edge before the edge that completes it. Contention, stall and fault cases first fill the FIFOs while the outputs are blocked. They then release the outputs and compare the recorded order with the order computed from the arbitration rules.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam int FLIT_W = 64;
  localparam int NPORT  = 5;
  localparam int DEST_W = 3;

  localparam logic [2:0] P_XP  = 3'd0;
  localparam logic [2:0] P_XM  = 3'd1;
  localparam logic [2:0] P_YP  = 3'd2;
  localparam logic [2:0] P_YM  = 3'd3;
  localparam logic [2:0] P_LOC = 3'd4;

  function automatic logic flit_head(input logic [FLIT_W-1:0] f);
    return f[FLIT_W-1];
  endfunction

  function automatic logic flit_tail(input logic [FLIT_W-1:0] f);
    return f[FLIT_W-2];
  endfunction

  function automatic logic [DEST_W-1:0] flit_dest(input logic [FLIT_W-1:0] f);
    return f[DEST_W-1:0];
  endfunction

  // Round-robin pick: first requester at or after ptr (mod n); {found, index}
  function automatic logic [3:0] rr_pick(input logic [7:0] req, input logic [2:0] ptr,
                                         input int n);
    logic [3:0] r;
    r = '0;
    for (int k = n - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(ptr) + k) % n;
      if (req[idx]) r = {1'b1, 3'(idx)};
    end
    return r;
  endfunction
endpackage

// File: rtl/fbr_vc_fifo.sv
module fbr_vc_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         not_full,
  input  logic         pop,
  output logic         not_empty,
  output logic [W-1:0] dout
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd, wr;
  logic [CW-1:0] cnt;

  assign not_full  = (cnt != CW'(DEPTH));
  assign not_empty = (cnt != '0);
  assign dout      = mem[rd];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd  <= '0;
      wr  <= '0;
      cnt <= '0;
    end else begin
      if (push) wr <= (wr == AW'(DEPTH - 1)) ? '0 : wr + 1'b1;
      if (pop)  rd <= (rd == AW'(DEPTH - 1)) ? '0 : rd + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr] <= din;
  end

  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH)));
endmodule

// File: rtl/fbr_in_unit.sv
module fbr_in_unit
  import fbr_pkg::*;
#(
  parameter int NVC   = 2,
  parameter int DEPTH = 4,
  localparam int VCW  = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VCW-1:0]    in_vc,
  input  logic [FLIT_W-1:0] in_flit,
  output logic [NVC-1:0]    in_ready,
  input  logic              pop,
  output logic              req_valid,
  output logic [FLIT_W-1:0] req_flit,
  output logic [VCW-1:0]    req_vc,
  output logic [DEST_W-1:0] req_dest
);
  logic [NVC-1:0]    ne;
  logic [FLIT_W-1:0] front [NVC];
  logic [VCW-1:0]    pick, sel_vc, cur_vc;
  logic              busy;
  logic [DEST_W-1:0] dest_q;

  for (genvar v = 0; v < NVC; v++) begin : g_vc
    logic push_v, pop_v;
    assign push_v = in_valid && (in_vc == VCW'(v)) && in_ready[v];
    assign pop_v  = pop && (sel_vc == VCW'(v));
    fbr_vc_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push_v), .din(in_flit), .not_full(in_ready[v]),
      .pop(pop_v), .not_empty(ne[v]), .dout(front[v]));
  end

  always_comb begin
    pick = '0;
    for (int v = NVC - 1; v >= 0; v--) if (ne[v]) pick = VCW'(v);
  end

  assign sel_vc    = busy ? cur_vc : pick;
  assign req_valid = ne[sel_vc];
  assign req_flit  = front[sel_vc];
  assign req_vc    = sel_vc;
  assign req_dest  = busy ? dest_q : flit_dest(front[pick]);

  // Lock channel and destination as soon as a packet is presented
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cur_vc <= '0;
      dest_q <= '0;
    end else begin
      if (!busy && |ne) begin
        busy   <= 1'b1;
        cur_vc <= pick;
        dest_q <= flit_dest(front[pick]);
      end
      if (pop && flit_tail(req_flit)) busy <= 1'b0;
    end
  end

  p_vc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flit_tail(req_flit)) |=> (req_vc == $past(req_vc)));
  p_pop_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> req_valid);
endmodule

// File: rtl/fbr_pkt_arb.sv
module fbr_pkt_arb
  import fbr_pkg::*;
#(
  parameter int N   = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  tail,
  input  logic          adv,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  logic          locked;
  logic [IW-1:0] lock_idx, ptr;
  logic [3:0]    pk;

  always_comb pk = rr_pick(8'(req), 3'(ptr), N);

  assign gnt_idx   = locked ? lock_idx : IW'(pk[2:0]);
  assign gnt_valid = locked ? req[lock_idx] : pk[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      lock_idx <= '0;
      ptr      <= '0;
    end else begin
      if (!locked && pk[3]) begin
        locked   <= 1'b1;
        lock_idx <= IW'(pk[2:0]);
      end
      if (adv && tail[gnt_idx]) begin
        locked <= 1'b0;
        ptr    <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
      end
    end
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !(adv && tail[gnt_idx])) |=> (gnt_idx == $past(gnt_idx)));
  p_adv_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> gnt_valid);
endmodule

// File: rtl/fbr_router.sv
module fbr_router
  import fbr_pkg::*;
#(
  parameter int NVC   = 2,
  parameter int DEPTH = 4,
  localparam int VCW  = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fault_xbar,
  input  logic                          fault_ni,
  input  logic [NPORT-1:0]              in_valid,
  input  logic [NPORT-1:0][VCW-1:0]     in_vc,
  input  logic [NPORT-1:0][FLIT_W-1:0]  in_flit,
  output logic [NPORT-1:0][NVC-1:0]     in_ready,
  output logic [NPORT-1:0]              out_valid,
  output logic [NPORT-1:0][VCW-1:0]     out_vc,
  output logic [NPORT-1:0][FLIT_W-1:0]  out_flit,
  input  logic [NPORT-1:0][NVC-1:0]     out_ready
);
  logic                ring_bypass;
  logic [NPORT-1:0]    r_valid, pop, tails, in_on_xbar, out_on_xbar;
  logic [FLIT_W-1:0]   r_flit [NPORT];
  logic [VCW-1:0]      r_vc   [NPORT];
  logic [DEST_W-1:0]   r_dest [NPORT];

  assign ring_bypass = fault_xbar | fault_ni;

  for (genvar p = 0; p < NPORT; p++) begin : g_in
    fbr_in_unit #(.NVC(NVC), .DEPTH(DEPTH)) u_in (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid[p]), .in_vc(in_vc[p]),
      .in_flit(in_flit[p]), .in_ready(in_ready[p]), .pop(pop[p]),
      .req_valid(r_valid[p]), .req_flit(r_flit[p]), .req_vc(r_vc[p]),
      .req_dest(r_dest[p]));
    assign tails[p]       = flit_tail(r_flit[p]);
    assign in_on_xbar[p]  = !fault_xbar && !(ring_bypass && (p == P_XM || p == P_LOC));
    assign out_on_xbar[p] = !fault_xbar && !(ring_bypass && (p == P_XP || p == P_LOC));
  end

  // Crossbar: one packet-locked arbiter per output
  logic [NPORT-1:0] x_gv, x_fire;
  logic [2:0]       x_gi [NPORT];

  for (genvar o = 0; o < NPORT; o++) begin : g_xbar
    logic [NPORT-1:0] xreq;
    always_comb begin
      for (int i = 0; i < NPORT; i++)
        xreq[i] = r_valid[i] && (r_dest[i] == DEST_W'(o)) && in_on_xbar[i] && out_on_xbar[o];
    end
    fbr_pkt_arb #(.N(NPORT)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(xreq), .tail(tails), .adv(x_fire[o]),
      .gnt_valid(x_gv[o]), .gnt_idx(x_gi[o]));
    assign x_fire[o] = x_gv[o] && out_ready[o][r_vc[x_gi[o]]];
  end

  // Ring-direction selector: backup lane (west input) vs local injection
  logic [1:0] rreq;
  logic       r_gv, r_fire;
  logic [0:0] r_gi;
  logic [2:0] r_src;

  assign rreq[0] = ring_bypass && r_valid[P_XM] && (r_dest[P_XM] != P_LOC);
  assign rreq[1] = ring_bypass && r_valid[P_LOC];
  fbr_pkt_arb #(.N(2)) u_ring (
    .clk(clk), .rst_n(rst_n), .req(rreq), .tail({tails[P_LOC], tails[P_XM]}),
    .adv(r_fire), .gnt_valid(r_gv), .gnt_idx(r_gi));
  assign r_src  = r_gi[0] ? P_LOC : P_XM;
  assign r_fire = r_gv && out_ready[P_XP][r_vc[r_src]];

  // Backup-lane ejection to the local core
  logic e_valid, e_fire;
  assign e_valid = ring_bypass && r_valid[P_XM] && (r_dest[P_XM] == P_LOC);
  assign e_fire  = e_valid && out_ready[P_LOC][r_vc[P_XM]];

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      out_valid[o] = x_gv[o];
      out_vc[o]    = r_vc[x_gi[o]];
      out_flit[o]  = r_flit[x_gi[o]];
    end
    if (ring_bypass) begin
      out_valid[P_XP]  = r_gv;
      out_vc[P_XP]     = r_vc[r_src];
      out_flit[P_XP]   = r_flit[r_src];
      out_valid[P_LOC] = e_valid;
      out_vc[P_LOC]    = r_vc[P_XM];
      out_flit[P_LOC]  = r_flit[P_XM];
    end
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NPORT; o++) if (x_fire[o]) pop[x_gi[o]] = 1'b1;
    if (r_fire) pop[r_src] = 1'b1;
    if (e_fire) pop[P_XM]  = 1'b1;
  end

  p_xbar_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_xbar |-> (out_valid[3:1] == '0));
  p_eject_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_bypass && out_valid[P_LOC] && flit_head(out_flit[P_LOC]))
      |-> (flit_dest(out_flit[P_LOC]) == P_LOC));
  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o][out_vc[o]] && $stable(fault_xbar) && $stable(fault_ni))
        |=> (out_valid[o] && out_flit[o] == $past(out_flit[o])));
  end
endmodule

// File: tb/sim_fbr_router.sv
`timescale 1ns/1ps
module sim_fbr_router;
  logic clk = 1'b0;
  logic rst_n;
  logic fault_xbar, fault_ni;
  logic [4:0]        in_valid;
  logic [4:0][0:0]   in_vc;
  logic [4:0][63:0]  in_flit;
  logic [4:0][1:0]   in_ready;
  logic [4:0]        out_valid;
  logic [4:0][0:0]   out_vc;
  logic [4:0][63:0]  out_flit;
  logic [4:0][1:0]   out_ready;

  int n_vec = 0;
  int n_err = 0;
  logic [67:0] mon_q[$];
  logic [67:0] exp_q[$];

  always #10 clk = ~clk;

  fbr_router u0 (
    .clk(clk), .rst_n(rst_n), .fault_xbar(fault_xbar), .fault_ni(fault_ni),
    .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit), .in_ready(in_ready),
    .out_valid(out_valid), .out_vc(out_vc), .out_flit(out_flit), .out_ready(out_ready));

  // record every output transfer that completes at the next rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < 5; o++)
        if (out_valid[o] && out_ready[o][out_vc[o]])
          mon_q.push_back({3'(o), out_vc[o], out_flit[o]});
    end
  end

  function automatic logic [63:0] mk(int seq, int len, int tag, int src, int dst);
    logic [63:0] f;
    f = '0;
    f[63] = (seq == 0);
    f[62] = (seq == len - 1);
    f[47:40] = 8'(tag);
    f[39:32] = 8'(seq);
    f[15:8]  = 8'(src);
    f[2:0]   = 3'(dst);
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [67:0] act, input logic [67:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input int p, input int vc, input int dst, input int len, input int tag);
    for (int s = 0; s < len; s++) begin
      @(negedge clk);
      in_valid[p] = 1'b1;
      in_vc[p]    = 1'(vc);
      in_flit[p]  = mk(s, len, tag, p, dst);
      while (!in_ready[p][vc]) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  task automatic add_exp(input int port, input int vc, input int src, input int dst,
                         input int len, input int tag);
    for (int s = 0; s < len; s++)
      exp_q.push_back({3'(port), 1'(vc), mk(s, len, tag, src, dst)});
  endtask

  task automatic check_q(input string req, input string what);
    bit ok;
    logic [67:0] a, e;
    ok = (mon_q.size() == exp_q.size());
    a = 68'(mon_q.size());
    e = 68'(exp_q.size());
    if (ok) begin
      for (int k = 0; k < exp_q.size(); k++)
        if (ok && mon_q[k] !== exp_q[k]) begin
          ok = 1'b0; a = mon_q[k]; e = exp_q[k];
        end
    end
    chk(ok, req, what, a, e);
    mon_q.delete();
    exp_q.delete();
  endtask

  // 4 packets of 2 flits on one port: contiguous packets, alternating sources
  task automatic check_alt(input int port, input string req_c, input string req_a);
    bit okc, oka;
    okc = (mon_q.size() == 8);
    oka = okc;
    if (okc) begin
      for (int k = 0; k < 8; k++) if (mon_q[k][67:65] != 3'(port)) okc = 1'b0;
      for (int k = 0; k < 4; k++)
        if (mon_q[2*k][47:40] != mon_q[2*k+1][47:40] || !mon_q[2*k][63] || !mon_q[2*k+1][62])
          okc = 1'b0;
      for (int k = 0; k < 3; k++)
        if (mon_q[2*k][15:8] == mon_q[2*k+2][15:8]) oka = 1'b0;
    end
    chk(okc, req_c, "packets contiguous on one output", 68'(mon_q.size()), 68'd8);
    chk(oka, req_a, "sources alternate per packet", 68'(okc), 68'd1);
    mon_q.delete();
  endtask

  task automatic send_two(input int p, input int dst, input int tag0);
    send_pkt(p, 0, dst, 2, tag0);
    send_pkt(p, 0, dst, 2, tag0 + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_err++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fault_xbar = 1'b0;
    fault_ni = 1'b0;
    in_valid = '0;
    in_vc = '0;
    in_flit = '0;
    out_ready = '1;
    ticks(3);
    chk(out_valid == '0, "R1", "out_valid in reset", 68'(out_valid), 68'd0);
    rst_n = 1'b1;
    ticks(1);
    chk(out_valid == '0, "R1", "out_valid after reset", 68'(out_valid), 68'd0);
    chk(in_ready == '1, "R1", "in_ready after reset", 68'(in_ready), 68'h3ff);

    // R2: every input to every destination, healthy router
    for (int p = 0; p < 5; p++)
      for (int d = 0; d < 5; d++) begin
        send_pkt(p, (p + d) % 2, d, 3, p * 5 + d);
        ticks(4);
        add_exp(d, (p + d) % 2, p, d, 3, p * 5 + d);
        check_q("R2", $sformatf("route in %0d to out %0d", p, d));
      end

    // R3: one-edge latency
    @(negedge clk);
    in_valid[2] = 1'b1; in_vc[2] = 1'b0; in_flit[2] = mk(0, 1, 40, 2, 3);
    chk(out_valid[3] == 1'b0, "R3", "output idle before edge", 68'(out_valid[3]), 68'd0);
    @(negedge clk);
    in_valid[2] = 1'b0;
    chk(out_valid[3] && out_flit[3] == mk(0, 1, 40, 2, 3), "R3", "flit visible after one edge",
        {3'b0, out_valid[3], out_flit[3]}, {4'b1, mk(0, 1, 40, 2, 3)});
    ticks(3);
    mon_q.delete();

    // R3 / R11: full FIFO and stalled output
    out_ready[3] = 2'b00;
    for (int k = 0; k < 4; k++) send_pkt(2, 0, 3, 1, 50 + k);
    chk(in_ready[2] == 2'b10, "R3", "vc0 full, vc1 free", 68'(in_ready[2]), 68'b10);
    for (int k = 0; k < 3; k++) begin
      chk(out_valid[3] && out_flit[3] == mk(0, 1, 50, 2, 3), "R11", "stalled flit held",
          {3'b0, out_valid[3], out_flit[3]}, {4'b1, mk(0, 1, 50, 2, 3)});
      ticks(1);
    end
    out_ready[3] = 2'b11;
    ticks(8);
    for (int k = 0; k < 4; k++) add_exp(3, 0, 2, 3, 1, 50 + k);
    check_q("R3", "stalled flits drain in order");

    // R4 / R5: two inputs, two packets each, same output
    out_ready[2] = 2'b00;
    fork
      send_two(0, 2, 60);
      send_two(3, 2, 70);
    join
    out_ready[2] = 2'b11;
    ticks(12);
    check_alt(2, "R4", "R5");

    // R6: VC0 served before VC1 once the input is free
    out_ready[1] = 2'b00;
    send_pkt(2, 0, 1, 2, 80);
    send_pkt(2, 1, 1, 2, 81);
    send_pkt(2, 0, 1, 2, 82);
    out_ready[1] = 2'b11;
    ticks(10);
    add_exp(1, 0, 2, 1, 2, 80);
    add_exp(1, 0, 2, 1, 2, 82);
    add_exp(1, 1, 2, 1, 2, 81);
    check_q("R6", "lowest VC first at packet boundary");

    // Crossbar fault
    fault_xbar = 1'b1;
    ticks(1);
    for (int d = 0; d < 5; d++) begin
      send_pkt(1, d % 2, d, 3, 90 + d);
      ticks(4);
      add_exp(d == 4 ? 4 : 0, d % 2, 1, d, 3, 90 + d);
      check_q("R9", $sformatf("backup lane dest %0d", d));
    end
    for (int d = 0; d < 5; d++) begin
      send_pkt(4, 1, d, 2, 100 + d);
      ticks(4);
      add_exp(0, 1, 4, d, 2, 100 + d);
      check_q("R8", $sformatf("local injection dest %0d goes east", d));
    end
    send_pkt(2, 0, 3, 2, 110);
    ticks(8);
    chk(mon_q.size() == 0 && out_valid[3:1] == 3'b000, "R7", "crossbar outputs idle",
        68'(mon_q.size()), 68'd0);
    out_ready[0] = 2'b00;
    fork
      send_two(1, 0, 120);
      send_two(4, 3, 130);
    join
    out_ready[0] = 2'b11;
    ticks(12);
    check_alt(0, "R4", "R8");
    fault_xbar = 1'b0;
    ticks(6);
    add_exp(3, 0, 2, 3, 2, 110);
    check_q("R7", "queued packet delivered after recovery");

    // Core interface fault only
    fault_ni = 1'b1;
    ticks(1);
    send_pkt(4, 0, 2, 2, 140); ticks(4);
    add_exp(0, 0, 4, 2, 2, 140); check_q("R10", "local injection east");
    send_pkt(2, 1, 3, 2, 141); ticks(4);
    add_exp(3, 1, 2, 3, 2, 141); check_q("R10", "north input via crossbar");
    send_pkt(0, 0, 1, 2, 142); ticks(4);
    add_exp(1, 0, 0, 1, 2, 142); check_q("R10", "east input via crossbar");
    send_pkt(1, 0, 4, 2, 143); ticks(4);
    add_exp(4, 0, 1, 4, 2, 143); check_q("R9", "west input ejects to core");
    send_pkt(1, 1, 2, 2, 144); ticks(4);
    add_exp(0, 1, 1, 2, 2, 144); check_q("R9", "west input forwarded east");
    fault_ni = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule